// File: doc/BRIEF.md
# Two-Wire Parallel-Input Serial Expander

This block lets a host read a 12-bit parallel word using only two control wires: a clock that the host drives, and one shared line that carries both the capture strobe from the host and the serial data back to it. The shared line is split here into an input, an output and an output-enable. The host starts a capture by pulling the shared line low while its clock is high. The block then loads the parallel word, takes over the line and drives it low. On each later falling host-clock edge it presents the next bit, lowest bit first. The thirteenth falling edge after the capture hands the line back to the host.

The host clock and the shared-line input are sampled on a fast system clock through a synchroniser, and edges are found from the synchronised samples. A saturating count of host-clock falling edges, cleared by each capture, returns the line to input mode after any 13 falling edges, whatever state the block was in. The parameter `START_IN_OUTPUT` picks the state the block leaves reset in, so that start-up in output mode can be modelled and tested.

Control states: `MODE_LISTEN` (line is an input, output-enable low) and `MODE_TALK` (block drives the line). Transitions: *capture* (`MODE_LISTEN` to `MODE_TALK`, on a line fall while the host clock is high) and *release* (`MODE_TALK` to `MODE_LISTEN`, on the falling edge that brings the edge count to 13).

Top module: `twowire_expander`

## Requirements
- R1: While reset is high and on the first cycle after it, `line_oe` is 0 and `line_o` is 0 (default `START_IN_OUTPUT`=0).
- R2: In input mode, a high-to-low change of `line_i` while `host_clk` is high loads `par_i` and asserts `line_oe` with `line_o` at 0.
- R3: After a capture, the k-th falling edge of `host_clk` (k = 1 to 12) makes `line_o` present bit k-1 of the captured word, where bit i of `par_i` is Di, so D0 comes first.
- R4: The 13th falling edge of `host_clk` after a capture deasserts `line_oe`; after 12 of them it is still asserted.
- R5: While `line_oe` is asserted, a line fall with the host clock high does not start a new capture: the bits still come from the earlier captured word.
- R6: A fall of `line_i` while `host_clk` is low does not capture; `line_oe` stays 0.
- R7: With `START_IN_OUTPUT`=1 the block leaves reset with `line_oe` asserted, keeps it after 12 falling host-clock edges, and deasserts it on the 13th.
- R8: In input mode, any number of host-clock edges leaves `line_oe` at 0, and a capture after them behaves as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the host clock |
| rst | input | 1 | Synchronous reset, active high |
| host_clk | input | 1 | Clock pin driven by the host |
| line_i | input | 1 | Level seen on the shared latch/data line |
| line_o | output | 1 | Level the block drives onto the shared line |
| line_oe | output | 1 | 1 while the block drives the shared line |
| par_i | input | 12 | Parallel word, bit i is Di |

## Verification
The main path is tried with random 12-bit words from a fixed seed, along with the all-zero, all-one and alternating words. Together they tell a correct D0-first order apart from a reversed order, an off-by-one bit position, or stuck serial data. Line falls made with the host clock low, and line falls forced while the block is driving, show that the capture condition depends on both the host clock level and the mode. A second instance that leaves reset in output mode is clocked through exactly 12 and then 13 falling edges. This shows that the release comes from the edge count and not from a capture.

// File: rtl/expander_pkg.sv
package expander_pkg;
    typedef enum logic {
        MODE_LISTEN = 1'b0,
        MODE_TALK   = 1'b1
    } mode_t;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/xp_edge.sv
module xp_edge (
    input  logic clk,
    input  logic rst,
    input  logic hclk_s,
    input  logic line_s,
    output logic hclk_fall,
    output logic hclk_high,
    output logic line_fall
);
    logic hclk_prev;
    logic line_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            hclk_prev <= 1'b0;
            line_prev <= 1'b0;
        end else begin
            hclk_prev <= hclk_s;
            line_prev <= line_s;
        end
    end

    assign hclk_fall = hclk_prev & ~hclk_s;
    assign hclk_high = hclk_s;
    assign line_fall = line_prev & ~line_s;
endmodule

// File: rtl/xp_ctrl.sv
module xp_ctrl
    import expander_pkg::*;
#(
    parameter int WIDTH           = 12,
    parameter bit START_IN_OUTPUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic hclk_fall,
    input  logic latch_req,
    output logic load_en,
    output logic shift_en,
    output logic drive_en
);
    localparam int LIMIT = WIDTH + 1;
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LIMIT - 1);
    localparam mode_t RESET_MODE = START_IN_OUTPUT ? MODE_TALK : MODE_LISTEN;

    mode_t            mode_q, mode_d;
    logic [CNT_W-1:0] fall_cnt;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_LISTEN: begin
                if (latch_req) mode_d = MODE_TALK;
            end
            MODE_TALK: begin
                if ((hclk_fall && fall_cnt == CNT_LAST) || fall_cnt == CNT_LIMIT)
                    mode_d = MODE_LISTEN;
            end
            default: mode_d = MODE_LISTEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= RESET_MODE;
        else     mode_q <= mode_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    fall_cnt <= '0;
        else if (mode_q == MODE_LISTEN && latch_req) fall_cnt <= '0;
        else if (hclk_fall && fall_cnt != CNT_LIMIT) fall_cnt <= fall_cnt + 1'b1;
    end

    always_comb begin
        load_en  = 1'b0;
        shift_en = 1'b0;
        drive_en = 1'b0;
        unique case (mode_q)
            MODE_LISTEN: load_en = latch_req;
            MODE_TALK: begin
                shift_en = hclk_fall;
                drive_en = ~rst;
            end
            default: ;
        endcase
    end

    // R7: the edge count never passes its saturation value
    a_r7_count_saturates: assert property (@(posedge clk) disable iff (rst)
        fall_cnt <= CNT_LIMIT);

    // R4: a full count of falling edges always means input mode
    a_r4_idle_after_limit: assert property (@(posedge clk) disable iff (rst)
        (fall_cnt == CNT_LIMIT) |-> (mode_q == MODE_LISTEN));

    // R5: a strobe while driving neither restarts the count nor leaves output mode
    a_r5_no_relatch: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TALK && latch_req && !hclk_fall) |=>
            (fall_cnt == $past(fall_cnt) && mode_q == MODE_TALK));
endmodule

// File: rtl/xp_shift.sv
module xp_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o
);
    localparam int SR_W = WIDTH + 1;

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)           sr_q <= '0;
        else if (load_en)  sr_q <= {par_i, 1'b0};
        else if (shift_en) sr_q <= {1'b0, sr_q[SR_W-1:1]};
    end

    assign ser_o = sr_q[0];

    // R2: a fresh load always puts the low leading bit on the output
    a_r2_load_low: assert property (@(posedge clk) disable iff (rst)
        load_en |=> !ser_o);
endmodule

// File: rtl/twowire_expander.sv
module twowire_expander #(
    parameter int WIDTH           = 12,
    parameter int SYNC_STAGES     = 2,
    parameter bit START_IN_OUTPUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_clk,
    input  logic             line_i,
    output logic             line_o,
    output logic             line_oe,
    input  logic [WIDTH-1:0] par_i
);
    logic [1:0] pins_s;
    logic       hclk_fall;
    logic       hclk_high;
    logic       line_fall;
    logic       latch_req;
    logic       load_en;
    logic       shift_en;
    logic       drive_en;
    logic       ser_bit;

    xp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({host_clk, line_i}),
        .sync_o  (pins_s)
    );

    xp_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .hclk_s    (pins_s[1]),
        .line_s    (pins_s[0]),
        .hclk_fall (hclk_fall),
        .hclk_high (hclk_high),
        .line_fall (line_fall)
    );

    assign latch_req = line_fall & hclk_high;

    xp_ctrl #(.WIDTH(WIDTH), .START_IN_OUTPUT(START_IN_OUTPUT)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .hclk_fall (hclk_fall),
        .latch_req (latch_req),
        .load_en   (load_en),
        .shift_en  (shift_en),
        .drive_en  (drive_en)
    );

    xp_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .shift_en (shift_en),
        .par_i    (par_i),
        .ser_o    (ser_bit)
    );

    assign line_oe = drive_en;
    assign line_o  = drive_en & ser_bit;

    // R2: a capture in input mode drives the line low on the next cycle
    a_r2_capture_drives_low: assert property (@(posedge clk) disable iff (rst)
        (!line_oe && line_fall && hclk_high) |=> (line_oe && !line_o));

    // R6: a line fall with the host clock low never takes the line
    a_r6_no_capture_clock_low: assert property (@(posedge clk) disable iff (rst)
        (!line_oe && line_fall && !hclk_high && !hclk_fall) |=> !line_oe);

    // R1: the line is never driven high while not enabled
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !line_oe |-> !line_o);
endmodule

// File: tb/twowire_expander_test.sv
module twowire_expander_test;
    localparam int W  = 12;
    localparam int HP = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         host_clk = 1'b1;
    logic         host_line = 1'b1;
    logic         force_en = 1'b0;
    logic [W-1:0] par = '0;
    logic         line_o, line_oe, line_o2, line_oe2;
    logic         line_i, line_i2;
    int           errors = 0;
    int           checks = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    assign line_i  = force_en ? host_line : (line_oe ? line_o : host_line);
    assign line_i2 = line_oe2 ? line_o2 : host_line;

    twowire_expander #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .host_clk(host_clk), .line_i(line_i),
        .line_o(line_o), .line_oe(line_oe), .par_i(par)
    );

    twowire_expander #(.WIDTH(W), .START_IN_OUTPUT(1'b1)) uut_rec (
        .clk(clk), .rst(rst), .host_clk(host_clk), .line_i(line_i2),
        .line_o(line_o2), .line_oe(line_oe2), .par_i(par)
    );

    function automatic logic exp_bit(input logic [W-1:0] word, input int k);
        return (k == 0) ? 1'b0 : word[k-1];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hfall();
        host_clk = 1'b0;
        wait_sys(HP);
    endtask

    task automatic hrise();
        host_clk = 1'b1;
        wait_sys(HP);
    endtask

    task automatic capture(input logic [W-1:0] word);
        par = word;
        host_line = 1'b1;
        wait_sys(HP);
        host_line = 1'b0;
        wait_sys(HP);
        host_line = 1'b1;
    endtask

    task automatic run_word(input logic [W-1:0] word, input bit poke);
        capture(word);
        check("R2 capture oe", line_oe, 1'b1);
        check("R2 capture low", line_o, exp_bit(word, 0));
        for (int k = 1; k <= W; k++) begin
            hfall();
            check("R3 bit", line_o, exp_bit(word, k));
            check("R4 still driving", line_oe, 1'b1);
            if (poke && k == 3) begin
                par = ~word;
                force_en = 1'b1;
                host_line = 1'b1;
                wait_sys(2);
            end
            hrise();
            if (poke && k == 3) begin
                host_line = 1'b0;
                wait_sys(HP);
                force_en = 1'b0;
                host_line = 1'b1;
                check("R5 no recapture", line_oe, 1'b1);
                check("R5 data held", line_o, exp_bit(word, k));
            end
        end
        hfall();
        check("R4 release", line_oe, 1'b0);
        hrise();
    endtask

    initial begin
        wait_sys(4);
        check("R1 oe in reset", line_oe, 1'b0);
        check("R1 line_o in reset", line_o, 1'b0);
        check("R1 rec oe in reset", line_oe2, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        wait_sys(1);
        check("R1 oe after reset", line_oe, 1'b0);
        check("R1 line_o after reset", line_o, 1'b0);
        check("R7 rec starts driving", line_oe2, 1'b1);
        wait_sys(HP);
        // R7 and R8: 12 falls keep the output-mode start driving, 13th releases
        for (int k = 1; k <= W; k++) begin
            hfall();
            hrise();
        end
        check("R7 rec after 12", line_oe2, 1'b1);
        check("R8 idle clocks", line_oe, 1'b0);
        hfall();
        check("R7 rec after 13", line_oe2, 1'b0);
        hrise();
        // R6: strobe with host clock low
        hfall();
        host_line = 1'b0;
        wait_sys(HP);
        check("R6 no capture clock low", line_oe, 1'b0);
        host_line = 1'b1;
        wait_sys(HP);
        hrise();
        check("R6 still idle", line_oe, 1'b0);
        run_word(12'h000, 1'b0);
        run_word(12'hFFF, 1'b0);
        run_word(12'hA5C, 1'b0);
        run_word(12'h555, 1'b1);
        // R8: many idle clocks then a normal capture
        for (int k = 0; k < 20; k++) begin
            hfall();
            hrise();
        end
        check("R8 idle after 20 clocks", line_oe, 1'b0);
        void'($urandom(32'd20240607));
        for (int n = 0; n < 24; n++) begin
            run_word(W'($urandom), (n % 6) == 5);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule